// File: doc/BRIEF.md
# Dual-Format Audio Serial Receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a frame clock that marks left and right halves, and one serial data line. The bit clock runs at 64 times the frame rate, so each channel gets 32 bit slots, and each channel carries a 24-bit word, most significant bit first. A static format input picks one of two framings. In MSB-justified framing the word starts right at the frame-clock transition. In I2S framing it starts one bit slot later.

The three serial wires are treated as asynchronous. They pass through multi-flop synchronisers into the system clock domain, and the block finds bit-clock rising edges there. Once the left word and then the right word of a frame are captured, the block updates both 24-bit output words and raises a one-cycle strobe. Frame rates from 8 kHz to 192 kHz are accepted as long as each bit-clock half period lasts at least three system clocks.

Top module: `audio_serial_rx`

## Requirements
- R1: During reset `valid_o` is 0 and both `left_o` and `right_o` are 0.
- R2: With `fmt_i2s`=0 (MSB-justified), a channel starts at each frame-clock transition. Frame clock 1 marks the left channel. The word's MSB is in slot 0, the first bit-clock rising edge that sees the new frame-clock level, and the other 23 bits follow MSB first in slots 1 to 23.
- R3: With `fmt_i2s`=1 (I2S), frame clock 0 marks the left channel. Slot 0 after the transition is ignored, and the word's MSB to LSB are in slots 1 to 24.
- R4: Serial data is taken at the rising edge of the bit clock. Data that changes while the bit clock is low is never mistaken for the current slot.
- R5: Slots outside the 24 word slots of a channel have no effect on the delivered words. These are slots 24 to 31 in MSB-justified framing, and slots 0 and 25 to 31 in I2S framing.
- R6: `valid_o` is high for exactly one system clock per delivered frame. `left_o` and `right_o` change only in that cycle and hold their values otherwise.
- R7: A frame is delivered only when a complete left word is followed by a complete right word. A left channel cut short, or a right word without a complete left word before it, produces no strobe.
- R8: A change of `fmt_i2s` discards the frame in progress and produces no strobe in the following cycle. Capture resumes at the next frame-clock transition, and the first complete frame after that is delivered.
- R9: Any bit-clock half period of three or more system clocks is accepted, and slot counting does not depend on the ratio between the clocks.
- R10: The strobe rises on the fourth system clock rising edge after the pins show the bit-clock rising edge that carries the right word's last bit. That edge count is two synchroniser stages, one capture register and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i2s | input | 1 | Framing select: 0 MSB-justified, 1 I2S |
| sclk_in | input | 1 | Serial bit clock, asynchronous |
| fclk_in | input | 1 | Frame (left/right) clock, asynchronous |
| sdata_in | input | 1 | Serial audio data, asynchronous |
| left_o | output | 24 | Last delivered left word |
| right_o | output | 24 | Last delivered right word |
| valid_o | output | 1 | One-cycle strobe when a new frame is delivered |

## Verification
The bench drives real serial streams in both framings and fills the unused slots with random bits. A design that picks the wrong MSB slot, or that shifts in the I2S leading slot or the trailing padding, then returns corrupted words. Data changes while the bit clock is low, so a design that samples on the falling edge reads the next slot's bit. The bench starts a left channel, cuts it short and follows it with a full right channel, and it also switches the format in the right half of a frame whose left word is already complete. A design without the pairing or discard logic would raise a strobe in these cases that the model does not expect. Every strobe is compared against the exact clock predicted from the pin activity, so a missing or extra pipeline stage, or a strobe longer than one cycle, shows up as a mismatch.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic {
      FMT_MSBJ = 1'b0,
      FMT_I2S  = 1'b1
   } fmt_e;

   // frame-clock level that marks the left channel
   function automatic logic left_level(input fmt_e f);
      return (f == FMT_MSBJ);
   endfunction

   // slot index (from the frame-clock transition) that carries the MSB
   function automatic int unsigned msb_slot(input fmt_e f);
      return (f == FMT_I2S) ? 1 : 0;
   endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic rise
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig;
   end

   assign rise = sig & ~prev_q;

endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
   import aud_rx_pkg::*;
#(
   parameter int WORD_W = 24,
   parameter int SLOT_W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_rise,
   input  logic lr,
   input  fmt_e fmt,
   input  logic fmt_chg,
   output logic cap_en,
   output logic cap_last,
   output logic cap_left,
   output logic start_en,
   output logic start_left
);

   localparam int              CNT_W    = $clog2(SLOT_W + 1);
   localparam logic [CNT_W-1:0] SLOT_MAX = CNT_W'(SLOT_W);
   localparam logic [CNT_W-1:0] SPAN     = CNT_W'(WORD_W - 1);

   logic             seen_q, prev_lr_q, armed_q, cur_left_q;
   logic [CNT_W-1:0] slot_q, slot_now, first_c, last_c;
   logic             lr_edge, lr_is_left;

   always_comb begin
      lr_edge    = seen_q && (lr != prev_lr_q);
      lr_is_left = (lr == left_level(fmt));
      slot_now   = lr_edge ? '0 : slot_q;
      first_c    = CNT_W'(msb_slot(fmt));
      last_c     = first_c + SPAN;
      start_en   = bclk_rise && !fmt_chg && lr_edge;
      start_left = lr_is_left;
      cap_en     = bclk_rise && !fmt_chg && (lr_edge || armed_q) &&
                   (slot_now >= first_c) && (slot_now <= last_c);
      cap_last   = cap_en && (slot_now == last_c);
      cap_left   = lr_edge ? lr_is_left : cur_left_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         prev_lr_q  <= 1'b0;
         armed_q    <= 1'b0;
         cur_left_q <= 1'b0;
         slot_q     <= '0;
      end else begin
         if (bclk_rise) begin
            prev_lr_q <= lr;
            seen_q    <= 1'b1;
         end
         if (fmt_chg) begin
            armed_q <= 1'b0;
         end else if (start_en) begin
            armed_q    <= 1'b1;
            cur_left_q <= lr_is_left;
            slot_q     <= CNT_W'(1);
         end else if (bclk_rise && slot_q != SLOT_MAX) begin
            slot_q <= slot_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/aud_rx_chan.sv
module aud_rx_chan #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cap,
   input  logic              cap_bit,
   input  logic              last,
   input  logic              clr,
   output logic [WORD_W-1:0] word_q,
   output logic              done_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         done_q <= 1'b0;
      end else begin
         if (cap) word_q <= {word_q[WORD_W-2:0], cap_bit};
         if (clr)              done_q <= 1'b0;
         else if (cap && last) done_q <= 1'b1;
         else if (start)       done_q <= 1'b0;
      end
   end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
   import aud_rx_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int SLOT_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fmt_i2s,
   input  logic              sclk_in,
   input  logic              fclk_in,
   input  logic              sdata_in,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o
);

   localparam int NCH = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (WORD_W + 1 > SLOT_W) begin : g_bad_slot
      $error("SLOT_W must leave room for the delayed framing");
   end

   logic [2:0] pins_s;
   logic       bclk_s, lr_s, data_s, bclk_rise;
   fmt_e       fmt;
   logic       fmt_q, fmt_chg;
   logic       cap_en, cap_last, cap_left, start_en, start_left;
   logic       fire;

   logic [WORD_W-1:0] ch_word [NCH];
   logic [NCH-1:0]    ch_done;

   aud_rx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sdata_in, fclk_in, sclk_in}),
      .q    (pins_s)
   );

   assign {data_s, lr_s, bclk_s} = pins_s;

   aud_rx_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (bclk_s),
      .rise (bclk_rise)
   );

   assign fmt = fmt_e'(fmt_i2s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fmt_q <= 1'b0;
      else        fmt_q <= fmt_i2s;
   end

   assign fmt_chg = (fmt_i2s != fmt_q);

   aud_rx_frame #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_rise (bclk_rise),
      .lr        (lr_s),
      .fmt       (fmt),
      .fmt_chg   (fmt_chg),
      .cap_en    (cap_en),
      .cap_last  (cap_last),
      .cap_left  (cap_left),
      .start_en  (start_en),
      .start_left(start_left)
   );

   assign fire = &ch_done;

   // channel 0 is left, channel 1 is right
   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic mine, own_start, clr;
      assign mine      = (c == 0) ? cap_left : !cap_left;
      assign own_start = start_en && (start_left == (c == 0));
      assign clr       = fire || fmt_chg ||
                         ((c == 1) && start_en && start_left);

      aud_rx_chan #(.WORD_W(WORD_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (own_start),
         .cap    (cap_en && mine),
         .cap_bit(data_s),
         .last   (cap_last),
         .clr    (clr),
         .word_q (ch_word[c]),
         .done_q (ch_done[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_o  <= '0;
         right_o <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= fire && !fmt_chg;
         if (fire && !fmt_chg) begin
            left_o  <= ch_word[0];
            right_o <= ch_word[1];
         end
      end
   end

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
   parameter int WORD_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fmt_i2s,
   input logic              bclk_rise,
   input logic              valid_o,
   input logic [WORD_W-1:0] left_o,
   input logic [WORD_W-1:0] right_o
);

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (!valid_o && left_o == '0 && right_o == '0));

   assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_hold_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   assert_fmt_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_i2s != $past(fmt_i2s)) |=> !valid_o);

   assert_strobe_after_bclk_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(bclk_rise, 2));

endmodule

bind audio_serial_rx aud_rx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fmt_i2s  (fmt_i2s),
   .bclk_rise(bclk_rise),
   .valid_o  (valid_o),
   .left_o   (left_o),
   .right_o  (right_o)
);

// File: tb/tb_audio_serial_rx.sv
`timescale 1ns/1ps
module tb_audio_serial_rx;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        fmt_i2s, sclk_in, fclk_in, sdata_in;
   logic [23:0] left_o, right_o;
   logic        valid_o;

   always #2.5 clk = ~clk;

   audio_serial_rx dut (
      .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s),
      .sclk_in(sclk_in), .fclk_in(fclk_in), .sdata_in(sdata_in),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   typedef struct {
      int          cyc;
      logic [23:0] l;
      logic [23:0] r;
      string       tag;
   } ev_t;

   ev_t         q[$];
   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;
   int          pulses = 0;
   int          hp = 3;
   bit          bfmt = 1'b0;
   logic [23:0] cur_l, cur_r;
   string       cur_tag;
   bit          done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic fail(input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
   endtask

   // reference model: strobe expected on the exact predicted clock
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         bit exp;
         exp = (q.size() > 0) && (q[0].cyc == cyc);
         if (valid_o) pulses++;
         if (valid_o || exp) begin
            checks++;
            if (valid_o !== exp)
               fail(exp ? q[0].tag : "R6", "strobe",
                    {47'd0, valid_o}, {47'd0, exp});
            else if (left_o !== q[0].l || right_o !== q[0].r)
               fail(q[0].tag, "words", {left_o, right_o}, {q[0].l, q[0].r});
            if (exp) void'(q.pop_front());
         end
      end
   end

   task automatic drive_slot(input logic lr, input logic d, input bit mark);
      @(negedge clk);
      sclk_in = 1'b0; fclk_in = lr; sdata_in = d;
      repeat (hp - 1) @(negedge clk);
      @(negedge clk);
      sclk_in = 1'b1;
      if (mark) q.push_back('{cyc + 4, cur_l, cur_r, cur_tag});
      repeat (hp - 1) @(negedge clk);
   endtask

   function automatic logic level(input bit is_left);
      return is_left ? !bfmt : bfmt;
   endfunction

   task automatic send_half(input bit is_left, input logic [23:0] w, input int len,
                            input bit mark, input int flip_at);
      int off;
      off = bfmt ? 1 : 0;
      for (int s = 0; s < len; s++) begin
         logic d;
         if (s == flip_at) fmt_i2s = ~fmt_i2s;
         if (s >= off && s < off + 24) d = w[23 - (s - off)];
         else                          d = 1'($urandom);
         drive_slot(level(is_left), d, mark && (s == off + 23));
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive_slot(level(1'b0), 1'($urandom), 1'b0);
   endtask

   task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                             input string tag);
      cur_l = l; cur_r = r; cur_tag = tag;
      send_half(1'b1, l, 32, 1'b0, -1);
      send_half(1'b0, r, 32, 1'b1, -1);
   endtask

   task automatic check_count(input string tag, input int base, input int exp);
      checks++;
      if (pulses - base != exp)
         fail(tag, "strobe count", 48'(pulses - base), 48'(exp));
   endtask

   task automatic set_fmt(input bit f);
      @(negedge clk);
      fmt_i2s = f; bfmt = f;
      idle(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int base;
      logic [23:0] hl, hr;
      rst_n = 1'b0; fmt_i2s = 1'b0; sclk_in = 1'b0; fclk_in = 1'b0; sdata_in = 1'b0;
      repeat (5) @(negedge clk);
      // R1: reset state
      checks++;
      if (valid_o !== 1'b0 || left_o !== '0 || right_o !== '0)
         fail("R1", "reset outputs", {left_o, right_o}, 48'd0);
      rst_n = 1'b1;
      idle(3);

      // R7: truncated left channel followed by a full right channel
      base = pulses;
      send_half(1'b1, 24'hABCDEF, 8, 1'b0, -1);
      send_half(1'b0, 24'h123456, 32, 1'b0, -1);
      check_count("R7", base, 0);

      // R2 / R4 / R5 / R10: MSB-justified frames at fast bit clock
      send_frame(24'h800001, 24'h7FFFFE, "R2");
      send_frame(24'hFFFFFF, 24'h000000, "R5");
      send_frame(24'($urandom), 24'($urandom), "R4");
      send_frame(24'($urandom), 24'($urandom), "R10");

      // R9: slower bit clock
      hp = 7;
      send_frame(24'h5A5A5A, 24'hA5A5A5, "R9");
      send_frame(24'($urandom), 24'($urandom), "R9");

      // R3: I2S framing
      set_fmt(1'b1);
      send_frame(24'h800000, 24'h000001, "R3");
      send_frame(24'($urandom), 24'($urandom), "R3");
      hp = 3;
      send_frame(24'($urandom), 24'($urandom), "R5");
      send_frame(24'hC00003, 24'h3FFFFC, "R3");

      // R8: format flip in the right half after a complete left word
      base = pulses;
      cur_l = 24'h111111; cur_r = 24'h222222; cur_tag = "R8";
      send_half(1'b1, 24'h111111, 32, 1'b0, -1);
      send_half(1'b0, 24'h222222, 32, 1'b0, 6);
      bfmt = fmt_i2s;
      idle(2);
      send_frame(24'h333333, 24'h444444, "R8");
      check_count("R8", base, 1);

      // R8: format flip in the left half, right half abandoned
      base = pulses;
      send_half(1'b1, 24'h555555, 32, 1'b0, 10);
      bfmt = fmt_i2s;
      idle(2);
      send_frame(24'h666666, 24'h777777, "R8");
      check_count("R8", base, 1);

      // R6: words hold through a frame that is not delivered
      repeat (8) @(negedge clk);
      hl = left_o; hr = right_o;
      base = pulses;
      send_half(1'b1, 24'h0F0F0F, 5, 1'b0, -1);
      send_half(1'b0, 24'hF0F0F0, 32, 1'b0, -1);
      repeat (8) @(negedge clk);
      check_count("R6", base, 0);
      checks++;
      if (left_o !== hl || right_o !== hr)
         fail("R6", "held words", {left_o, right_o}, {hl, hr});

      repeat (10) @(negedge clk);
      checks++;
      if (q.size() != 0) fail("R10", "pending strobes", 48'(q.size()), 48'd0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule